// File: doc/BRIEF.md
# Capability PTE Fault Prioritizer

This block judges one explicit data access in a core that carries a validity tag on every capability and runs with paged virtual memory. Each cycle it captures a description of the access: whether it is a load, a store or an atomic, and whether it moves a capability. It also captures the tag leaving the core and the tag arriving from memory, and the two capability bits of the leaf page entry. These are a write-permit bit and a generation bit. The other inputs are the current privilege level's generation bit and the ordinary faults that the address pipeline has already found. One cycle later it reports whether the access traps, the exception cause, and a secondary trap value. The secondary value tells software whether an ordinary page fault, a capability page-entry fault, or both were found. It also says when a capability load must deliver its value with the tag cleared.

Capability page-entry faults add no cause code. They use the load page fault (13) and the store/atomic page fault (15) codes. They fall into two classes. The urgent class ranks with ordinary translation faults. The deferred class applies to loads whose returned tag is inspected, and it wins only when nothing else fires. A conservative-mode input lets the deferred class fire without looking at the returned tag. Page-table walking, the trap CSRs and trap delivery are left to neighbouring blocks.

Top module: `cap_pte_prio`

## Requirements
- R1: A capability load or atomic that completes without a trap, with translation on and a leaf entry whose write-permit bit is clear, asserts `tag_clr_o`. No other access asserts it.
- R2: With translation on and the leaf entry's write-permit and generation bits both clear, a capability store or atomic whose outgoing tag is set raises cause 15 as an urgent capability fault.
- R3: With translation on, a capability load or atomic on a page whose write-permit bit is set and whose generation bit differs from `priv_crg_i` is a barrier access. If `ld_tag_chk_i` is 0 it is an urgent capability fault. If it is 1, it is a deferred fault only when `ld_tag_i` or `conserv_i` is set.
- R4: An urgent capability fault or an ordinary page fault uses cause 13 for a load and cause 15 for a store or atomic. A deferred capability fault always uses cause 13.
- R5: For a page-fault trap, `tval2_o` is 0 when only the ordinary page fault was found, 1 when only a capability fault was found, and 2 when both were found. It is 0 for every other trap.
- R6: Exactly one cause is reported, in this priority order. First comes early misalignment (4 for a load, 6 otherwise). Next comes a walk access fault (5/7), which also suppresses capability faults because the leaf was not reached. Then come the ordinary or urgent capability page faults (13/15), then the physical access fault (5/7), then late misalignment (4/6), and last the deferred capability fault (13). Access kind encoding: 0 load, 1 store, 2 atomic. Walk result encoding: 0 none, 1 page fault, 2 access fault.
- R7: With `xlate_en_i` low, walk results and all capability page-entry checks are ignored. No page fault is raised and `tag_clr_o` stays low.
- R8: While `in_valid_i` was low, and after reset, `trap_o`, `cause_o`, `tval2_o` and `tag_clr_o` are all zero.
- R9: The inputs are registered once. The outputs describe the access sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | An access is presented this cycle |
| xlate_en_i | input | 1 | Virtual memory translation is active |
| acc_kind_i | input | 2 | 0 load, 1 store, 2 atomic |
| acc_cap_i | input | 1 | Access moves a capability |
| st_tag_i | input | 1 | Tag of the capability being written |
| ld_tag_i | input | 1 | Tag of the capability read from memory |
| ld_tag_chk_i | input | 1 | Returned tag is inspected for the barrier check |
| pte_cw_i | input | 1 | Leaf entry capability write-permit bit |
| pte_crg_i | input | 1 | Leaf entry capability generation bit |
| priv_crg_i | input | 1 | Current privilege level generation bit |
| conserv_i | input | 1 | Raise checked barrier faults regardless of returned tag |
| walk_res_i | input | 2 | 0 no walk fault, 1 page fault, 2 access fault |
| misal_early_i | input | 1 | Misalignment reported ahead of translation |
| phys_af_i | input | 1 | Access fault on the physical address |
| misal_late_i | input | 1 | Misalignment reported after translation |
| trap_o | output | 1 | Access traps |
| cause_o | output | CAUSE_W | Exception cause code |
| tval2_o | output | TVAL_W | Secondary trap value |
| tag_clr_o | output | 1 | Deliver loaded capability with tag cleared |

## Verification
The assertions assume that the kind and walk-result inputs never carry their reserved code 3. They also assume the fault flags describe one access sampled on a single edge. The stimulus keeps within this range. The exhaustive sweep skips every vector that holds a reserved code. The random phase maps each draw onto the three legal kinds and the three legal walk results, and it also toggles `in_valid_i` and reset.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_AMO   = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        WALK_OK = 2'd0,
        WALK_PF = 2'd1,
        WALK_AF = 2'd2
    } walk_res_e;

    typedef struct packed {
        logic      valid;
        logic      xlate;
        acc_kind_e kind;
        logic      cap;
        logic      st_tag;
        logic      ld_tag;
        logic      tag_chk;
        logic      pte_cw;
        logic      pte_crg;
        logic      priv_crg;
        logic      conserv;
        walk_res_e walk;
        logic      misal_early;
        logic      phys_af;
        logic      misal_late;
    } acc_req_t;

    typedef struct packed {
        logic urgent;
        logic deferred;
        logic tag_clr;
    } cap_verdict_t;

    localparam int unsigned C_LD_MISAL = 4;
    localparam int unsigned C_LD_AF    = 5;
    localparam int unsigned C_ST_MISAL = 6;
    localparam int unsigned C_ST_AF    = 7;
    localparam int unsigned C_LD_PF    = 13;
    localparam int unsigned C_ST_PF    = 15;

    localparam logic [1:0] TV_PLAIN = 2'd0;
    localparam logic [1:0] TV_CAP   = 2'd1;
    localparam logic [1:0] TV_BOTH  = 2'd2;

    function automatic logic reads_mem(acc_kind_e k);
        return (k == ACC_LOAD) || (k == ACC_AMO);
    endfunction

    function automatic logic writes_mem(acc_kind_e k);
        return (k == ACC_STORE) || (k == ACC_AMO);
    endfunction

    function automatic int unsigned misal_code(acc_kind_e k);
        return (k == ACC_LOAD) ? C_LD_MISAL : C_ST_MISAL;
    endfunction

    function automatic int unsigned af_code(acc_kind_e k);
        return (k == ACC_LOAD) ? C_LD_AF : C_ST_AF;
    endfunction

    function automatic int unsigned pf_code(acc_kind_e k);
        return (k == ACC_LOAD) ? C_LD_PF : C_ST_PF;
    endfunction

endpackage

// File: rtl/cpf_cap_check.sv
module cpf_cap_check
    import cpf_pkg::*;
(
    input  acc_req_t     req,
    output cap_verdict_t verdict
);
    logic leaf_seen;
    logic rd_side;
    logic wr_side;
    logic st_block;
    logic barrier;

    always_comb begin
        leaf_seen = req.valid && req.xlate && (req.walk != WALK_AF);
        rd_side   = req.cap && reads_mem(req.kind);
        wr_side   = req.cap && writes_mem(req.kind);
        st_block  = leaf_seen && wr_side && req.st_tag && !req.pte_cw && !req.pte_crg;
        barrier   = leaf_seen && rd_side && req.pte_cw && (req.pte_crg != req.priv_crg);

        verdict.urgent   = st_block || (barrier && !req.tag_chk);
        verdict.deferred = barrier && req.tag_chk && (req.ld_tag || req.conserv);
        verdict.tag_clr  = leaf_seen && rd_side && !req.pte_cw;
    end
endmodule

// File: rtl/cpf_arbiter.sv
module cpf_arbiter
    import cpf_pkg::*;
#(
    parameter int CAUSE_W = 6,
    parameter int TVAL_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_req_t          req,
    input  cap_verdict_t      verdict,
    output logic              trap,
    output logic [CAUSE_W-1:0] cause,
    output logic [TVAL_W-1:0] tval2
);
    localparam int N_RANK = 6;

    logic        hit  [N_RANK];
    int unsigned code [N_RANK];
    logic [1:0]  tv   [N_RANK];
    logic        walk_pf;
    logic        walk_af;

    always_comb begin
        walk_pf = req.xlate && (req.walk == WALK_PF);
        walk_af = req.xlate && (req.walk == WALK_AF);

        hit[0] = req.misal_early;
        code[0] = misal_code(req.kind);
        tv[0] = TV_PLAIN;

        hit[1] = walk_af;
        code[1] = af_code(req.kind);
        tv[1] = TV_PLAIN;

        hit[2] = walk_pf || verdict.urgent;
        code[2] = pf_code(req.kind);
        tv[2] = !verdict.urgent ? TV_PLAIN : (walk_pf ? TV_BOTH : TV_CAP);

        hit[3] = req.phys_af;
        code[3] = af_code(req.kind);
        tv[3] = TV_PLAIN;

        hit[4] = req.misal_late;
        code[4] = misal_code(req.kind);
        tv[4] = TV_PLAIN;

        hit[5] = verdict.deferred;
        code[5] = C_LD_PF;
        tv[5] = TV_CAP;
    end

    logic        sel_hit;
    int unsigned sel_code;
    logic [1:0]  sel_tv;

    always_comb begin
        sel_hit  = 1'b0;
        sel_code = 0;
        sel_tv   = TV_PLAIN;
        for (int r = N_RANK - 1; r >= 0; r--) begin
            if (hit[r]) begin
                sel_hit  = 1'b1;
                sel_code = code[r];
                sel_tv   = tv[r];
            end
        end
        trap  = req.valid && sel_hit;
        cause = trap ? CAUSE_W'(sel_code) : '0;
        tval2 = trap ? TVAL_W'(sel_tv) : '0;
    end

    // R6: a walk access fault outranks every capability fault
    a_r6_walk_af_wins: assert property (@(posedge clk) disable iff (rst)
        (req.valid && walk_af && !req.misal_early) |-> (trap && (cause == CAUSE_W'(af_code(req.kind)))));

    // R5: a nonzero secondary value only accompanies a page-fault cause
    a_r5_tval_page_only: assert property (@(posedge clk) disable iff (rst)
        (tval2 != '0) |-> (trap && ((cause == CAUSE_W'(C_LD_PF)) || (cause == CAUSE_W'(C_ST_PF)))));

    // R4: the deferred class never uses the store cause
    a_r4_deferred_cause: assert property (@(posedge clk) disable iff (rst)
        (trap && verdict.deferred && !verdict.urgent && !walk_pf && !walk_af && !req.misal_early
              && !req.phys_af && !req.misal_late) |-> (cause == CAUSE_W'(C_LD_PF)));
endmodule

// File: rtl/cap_pte_prio.sv
module cap_pte_prio
    import cpf_pkg::*;
#(
    parameter int CAUSE_W = 6,
    parameter int TVAL_W  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid_i,
    input  logic               xlate_en_i,
    input  logic [1:0]         acc_kind_i,
    input  logic               acc_cap_i,
    input  logic               st_tag_i,
    input  logic               ld_tag_i,
    input  logic               ld_tag_chk_i,
    input  logic               pte_cw_i,
    input  logic               pte_crg_i,
    input  logic               priv_crg_i,
    input  logic               conserv_i,
    input  logic [1:0]         walk_res_i,
    input  logic               misal_early_i,
    input  logic               phys_af_i,
    input  logic               misal_late_i,
    output logic               trap_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [TVAL_W-1:0]  tval2_o,
    output logic               tag_clr_o
);
    acc_req_t     req_d;
    acc_req_t     req_q;
    cap_verdict_t verdict;
    logic         trap_w;

    always_comb begin
        req_d.valid       = in_valid_i;
        req_d.xlate       = xlate_en_i;
        req_d.kind        = acc_kind_e'(acc_kind_i);
        req_d.cap         = acc_cap_i;
        req_d.st_tag      = st_tag_i;
        req_d.ld_tag      = ld_tag_i;
        req_d.tag_chk     = ld_tag_chk_i;
        req_d.pte_cw      = pte_cw_i;
        req_d.pte_crg     = pte_crg_i;
        req_d.priv_crg    = priv_crg_i;
        req_d.conserv     = conserv_i;
        req_d.walk        = walk_res_e'(walk_res_i);
        req_d.misal_early = misal_early_i;
        req_d.phys_af     = phys_af_i;
        req_d.misal_late  = misal_late_i;
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    cpf_cap_check u_check (
        .req     (req_q),
        .verdict (verdict)
    );

    cpf_arbiter #(
        .CAUSE_W (CAUSE_W),
        .TVAL_W  (TVAL_W)
    ) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req_q),
        .verdict (verdict),
        .trap    (trap_w),
        .cause   (cause_o),
        .tval2   (tval2_o)
    );

    assign trap_o    = trap_w;
    assign tag_clr_o = verdict.tag_clr && !trap_w;

    // R8: an empty slot produces nothing
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_q.valid |-> (!trap_o && !tag_clr_o && (cause_o == '0) && (tval2_o == '0)));

    // R9: no trap can follow a cycle with no access presented
    a_r9_one_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid_i) |-> !trap_o);

    // R7: without translation no page-fault cause appears
    a_r7_no_xlate: assert property (@(posedge clk) disable iff (rst)
        !req_q.xlate |-> (!tag_clr_o && (tval2_o == '0)
                          && (cause_o != CAUSE_W'(C_LD_PF)) && (cause_o != CAUSE_W'(C_ST_PF))));

    // R1: tag clearing only for capability reads on a write-protected leaf
    a_r1_tag_clr_scope: assert property (@(posedge clk) disable iff (rst)
        tag_clr_o |-> (req_q.cap && !req_q.pte_cw && (req_q.kind != ACC_STORE) && !trap_o));
endmodule

// File: tb/cap_pte_prio_test.sv
module cap_pte_prio_test;
    import cpf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 6;
    localparam int TW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid_i = 0, xlate_en_i = 0, acc_cap_i = 0, st_tag_i = 0, ld_tag_i = 0;
    logic ld_tag_chk_i = 0, pte_cw_i = 0, pte_crg_i = 0, priv_crg_i = 0, conserv_i = 0;
    logic misal_early_i = 0, phys_af_i = 0, misal_late_i = 0;
    logic [1:0] acc_kind_i = 0, walk_res_i = 0;
    logic trap_o, tag_clr_o;
    logic [CW-1:0] cause_o;
    logic [TW-1:0] tval2_o;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_pte_prio #(.CAUSE_W(CW), .TVAL_W(TW)) uut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .xlate_en_i(xlate_en_i),
        .acc_kind_i(acc_kind_i), .acc_cap_i(acc_cap_i), .st_tag_i(st_tag_i),
        .ld_tag_i(ld_tag_i), .ld_tag_chk_i(ld_tag_chk_i), .pte_cw_i(pte_cw_i),
        .pte_crg_i(pte_crg_i), .priv_crg_i(priv_crg_i), .conserv_i(conserv_i),
        .walk_res_i(walk_res_i), .misal_early_i(misal_early_i), .phys_af_i(phys_af_i),
        .misal_late_i(misal_late_i), .trap_o(trap_o), .cause_o(cause_o),
        .tval2_o(tval2_o), .tag_clr_o(tag_clr_o)
    );

    typedef struct packed {
        logic v, x; logic [1:0] k; logic c, st, lt, chk, cw, crg, pcrg, cons;
        logic [1:0] w; logic me, pa, ml;
    } vec_t;

    typedef struct packed { logic trap; int cause; int tv; logic clr; } exp_t;

    // Reference built from the requirement text
    function automatic exp_t model(vec_t t);
        exp_t e;
        logic is_ld, is_st, rd, wr, xl, reach, urg, dfr, opf, oaf;
        int pf, af, ma;
        e = '0;
        if (!t.v) return e;                                   // R8
        is_ld = (t.k == 2'd0);
        is_st = (t.k == 2'd1);
        rd = t.c && !is_st;
        wr = t.c && !is_ld;
        xl = t.x;
        opf = xl && (t.w == 2'd1);
        oaf = xl && (t.w == 2'd2);
        reach = xl && !oaf;                                   // R7
        urg = reach && ((wr && t.st && !t.cw && !t.crg)       // R2
                     || (rd && t.cw && (t.crg ^ t.pcrg) && !t.chk)); // R3
        dfr = reach && rd && t.cw && (t.crg ^ t.pcrg) && t.chk && (t.lt || t.cons);
        pf = is_ld ? 13 : 15;
        af = is_ld ? 5 : 7;
        ma = is_ld ? 4 : 6;
        e.trap = 1'b1;
        if (t.me)            e.cause = ma;                    // R6 order
        else if (oaf)        e.cause = af;
        else if (opf || urg) begin e.cause = pf; e.tv = urg ? (opf ? 2 : 1) : 0; end // R4 R5
        else if (t.pa)       e.cause = af;
        else if (t.ml)       e.cause = ma;
        else if (dfr)        begin e.cause = 13; e.tv = 1; end
        else                 e.trap = 1'b0;
        e.clr = !e.trap && reach && rd && !t.cw;              // R1
        return e;
    endfunction

    task automatic drive(vec_t t);
        in_valid_i = t.v; xlate_en_i = t.x; acc_kind_i = t.k; acc_cap_i = t.c;
        st_tag_i = t.st; ld_tag_i = t.lt; ld_tag_chk_i = t.chk; pte_cw_i = t.cw;
        pte_crg_i = t.crg; priv_crg_i = t.pcrg; conserv_i = t.cons; walk_res_i = t.w;
        misal_early_i = t.me; phys_af_i = t.pa; misal_late_i = t.ml;
    endtask

    task automatic compare(exp_t e, string tag);
        string req;
        n_run++;
        if (trap_o !== e.trap || cause_o !== CW'(e.cause) || tval2_o !== TW'(e.tv) || tag_clr_o !== e.clr) begin
            n_fail++;
            if (tag_clr_o !== e.clr) req = "R1";
            else if (tval2_o !== TW'(e.tv)) req = "R5";
            else req = tag;
            $display("FAIL %s: got trap=%0b cause=%0d tv=%0d clr=%0b, want trap=%0b cause=%0d tv=%0d clr=%0b",
                     req, trap_o, cause_o, tval2_o, tag_clr_o, e.trap, e.cause, e.tv, e.clr);
        end
    endtask

    // One vector per cycle: drive at falling edge, registered at rising edge, checked at next falling edge
    task automatic step(vec_t t, string tag);
        drive(t);
        @(negedge clk);
        compare(model(t), tag);
    endtask

    function automatic vec_t base();
        vec_t t;
        t = '0; t.v = 1; t.x = 1; t.c = 1;
        return t;
    endfunction

    initial begin
        vec_t t;
        exp_t z;
        z = '0;
        repeat (3) @(negedge clk);
        compare(z, "R8");                                     // R8 reset state
        rst = 1'b0;
        @(negedge clk);
        compare(z, "R8");

        // R2 directed: store of tagged capability into no-capability page
        t = base(); t.k = 2'd1; t.st = 1;
        step(t, "R2");
        // R9: immediately after driving, the output still shows the earlier vector
        drive(base());
        #1;
        n_run++;
        if (trap_o !== 1'b1 || cause_o !== CW'(15)) begin
            n_fail++;
            $display("FAIL R9: got trap=%0b cause=%0d, want trap=1 cause=15", trap_o, cause_o);
        end
        @(negedge clk);
        compare(model(base()), "R9");
        // R3 deferred barrier on a checked load with tag set
        t = base(); t.cw = 1; t.crg = 1; t.chk = 1; t.lt = 1;
        step(t, "R3");
        // R3 conservative mode with tag clear
        t.lt = 0; t.cons = 1;
        step(t, "R3");
        // R5 both faults at once on an atomic
        t = base(); t.k = 2'd2; t.st = 1; t.w = 2'd1;
        step(t, "R5");
        // R7 translation off hides everything PTE related
        t.x = 0;
        step(t, "R7");
        // R1 capability load from write-protected leaf
        t = base();
        step(t, "R1");
        // R8 invalid slot with every fault flag set
        t = '1; t.v = 0; t.k = 2'd1; t.w = 2'd2;
        step(t, "R8");

        // R6 exhaustive sweep of all legal encodings
        for (int i = 0; i < 65536; i++) begin
            vec_t s;
            s = vec_t'({1'b1, 16'(i)});
            if (s.k == 2'd3 || s.w == 2'd3) continue;
            step(s, s.x ? "R6" : "R7");
        end

        // Random phase with reset and valid toggling
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            vec_t s;
            s = vec_t'(17'($urandom));
            s.k = 2'($urandom_range(0, 2));
            s.w = 2'($urandom_range(0, 2));
            if ((i % 500) == 499) begin
                rst = 1'b1;
                drive(s);
                @(negedge clk);
                compare(z, "R8");
                rst = 1'b0;
            end else begin
                step(s, s.v ? "R6" : "R8");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9: watchdog expired, got running, want finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule